// File: doc/BRIEF.md
# UART Register Bank and Interrupt Controller

This block is the control and status register file of a serial port. A simple word-oriented read/write bus addresses it through a 12-bit byte offset, and the register index is that offset divided by four. The bank holds the configuration registers for the serial engine: the IrDA low-power divisor, the integer and fractional baud divisors, line control, control, FIFO level select and DMA control. Each of these values is driven out to the neighbouring logic. The bank also serves a fixed block of identification bytes near the top of the 4 KB window.

The bank connects to the FIFO and the transmitter. A write to the data register passes the low byte to the transmitter as a one-cycle strobe. A read of the data register returns the word that the receive FIFO presents and pulses a pop strobe. The upper bits of that word are captured as the receive error status.

The interrupt logic keeps four things apart: the raw status, the mask, the masked status and a write-one-to-clear register. The single interrupt output is high whenever any masked bit is set.

Top module: `uart_regbank`

## Requirements
- R1: After reset the control register (index 12) reads 0x300, the FIFO level register (index 13) reads 0x12, and the mask (index 14), raw status (index 15) and interrupt output are all zero.
- R2: The configuration registers keep the written value truncated to their width and read it back at their index: 8 ilpr 8 bits, 9 ibrd 16 bits, 10 fbrd 6 bits, 11 lcr 8 bits, 12 cr 16 bits, 13 ifls 6 bits, 18 dmacr 3 bits.
- R3: A write to index 0 pulses tx_wr_o for that cycle, with tx_byte_o equal to wdata bits 7:0, and sets raw status bit 5. A read of index 0 pulses rx_rd_o and returns rx_word_i.
- R4: The masked status (index 16) reads raw AND mask, and irq_o equals the OR of the masked bits. irq_o follows a mask or raw status change on the same clock edge that updates the register.
- R5: A write to index 17 clears each raw status bit written as 1 and leaves the others unchanged.
- R6: rx_irq_set_i sets raw bit 4 and rx_irq_clr_i clears it. When both are high in the same cycle, the set wins.
- R7: Index 6 returns flags_i. Writes to indices 6, 15, 16 and to the identification range change nothing.
- R8: A data read loads the receive status (index 1) with rx_word_i bits 11:8. Any write to index 1 clears it to zero.
- R9: Reads of offsets 0xFE0 to 0xFFC, in ascending order, return 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Reads of unmapped offsets, including the write-only clear register, return zero.
- R11: Read data appears on rdata_o with rvalid_o high in the cycle after the request, and rvalid_o is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| tx_wr_o | output | 1 | Transmit byte strobe |
| tx_byte_o | output | 8 | Transmit byte |
| rx_rd_o | output | 1 | Receive FIFO pop strobe |
| rx_word_i | input | 12 | Receive FIFO head word (error bits 11:8, data 7:0) |
| flags_i | input | 9 | FIFO and line flags |
| rx_irq_set_i | input | 1 | Receive interrupt event |
| rx_irq_clr_i | input | 1 | Receive interrupt withdraw |
| irq_o | output | 1 | Combined interrupt |
| ilpr_o | output | 8 | IrDA low-power divisor |
| ibrd_o | output | 16 | Integer baud divisor |
| fbrd_o | output | 6 | Fractional baud divisor |
| lcr_o | output | 8 | Line control |
| cr_o | output | 16 | Control |
| ifls_o | output | 6 | FIFO level select |
| dmacr_o | output | 3 | DMA control |

## Verification
Read data is due one cycle after the request. Each read expectation goes into a queue before the request is driven. A monitor pops it on the falling edge after the capturing edge, and any read data that arrives with no expectation waiting counts as a failure. The transmit and pop strobes are combinational from the request, so they are sampled 1 ns after the request is driven, inside the same cycle. Register updates and irq_o are due at the edge that ends the access, so they are checked on the falling edge that follows it.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = ADDR_W - 2;
    localparam int NIRQ    = 11;
    localparam int TX_BIT  = 5;
    localparam int RX_BIT  = 4;
    localparam int RSR_W   = 4;
    localparam int ID_N    = 8;
    localparam int ID_SEL_W = $clog2(ID_N);
    localparam logic [IDX_W-1:0] ID_BASE = 10'h3F8;

    localparam logic [IDX_W-1:0] IX_DATA  = 10'd0;
    localparam logic [IDX_W-1:0] IX_RSR   = 10'd1;
    localparam logic [IDX_W-1:0] IX_FLAG  = 10'd6;
    localparam logic [IDX_W-1:0] IX_ILPR  = 10'd8;
    localparam logic [IDX_W-1:0] IX_IBRD  = 10'd9;
    localparam logic [IDX_W-1:0] IX_FBRD  = 10'd10;
    localparam logic [IDX_W-1:0] IX_LCR   = 10'd11;
    localparam logic [IDX_W-1:0] IX_CR    = 10'd12;
    localparam logic [IDX_W-1:0] IX_IFLS  = 10'd13;
    localparam logic [IDX_W-1:0] IX_MASK  = 10'd14;
    localparam logic [IDX_W-1:0] IX_RAW   = 10'd15;
    localparam logic [IDX_W-1:0] IX_MIS   = 10'd16;
    localparam logic [IDX_W-1:0] IX_CLR   = 10'd17;
    localparam logic [IDX_W-1:0] IX_DMA   = 10'd18;

    localparam logic [15:0] CR_RST   = 16'h0300;
    localparam logic [5:0]  IFLS_RST = 6'h12;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic [RSR_W-1:0]  rsr;
        logic [7:0]        ilpr;
        logic [15:0]       ibrd;
        logic [5:0]        fbrd;
        logic [7:0]        lcr;
        logic [15:0]       cr;
        logic [5:0]        ifls;
        logic [2:0]        dmacr;
    } bank_t;
endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
    import uart_regbank_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [IDX_W-1:0]    idx_o,
    output logic                is_id_o,
    output logic [ID_SEL_W-1:0] id_sel_o
);
    logic [IDX_W-1:0] rel;

    always_comb begin
        idx_o    = addr_i[ADDR_W-1:2];
        rel      = idx_o - ID_BASE;
        is_id_o  = (idx_o >= ID_BASE) && (rel < IDX_W'(ID_N));
        id_sel_o = rel[ID_SEL_W-1:0];
    end
endmodule

// File: rtl/uart_regbank_idrom.sv
module uart_regbank_idrom
    import uart_regbank_pkg::*;
(
    input  logic [ID_SEL_W-1:0] sel_i,
    output logic [7:0]          byte_o
);
    always_comb begin
        unique case (sel_i)
            3'd0:    byte_o = 8'h11;
            3'd1:    byte_o = 8'h10;
            3'd2:    byte_o = 8'h14;
            3'd3:    byte_o = 8'h00;
            3'd4:    byte_o = 8'h0D;
            3'd5:    byte_o = 8'hF0;
            3'd6:    byte_o = 8'h05;
            default: byte_o = 8'hB1;
        endcase
    end
endmodule

// File: rtl/uart_regbank_irq.sv
module uart_regbank_irq
    import uart_regbank_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_we_i,
    input  logic [NIRQ-1:0] mask_wdata_i,
    input  logic            clr_we_i,
    input  logic [NIRQ-1:0] clr_wdata_i,
    input  logic            tx_set_i,
    input  logic            rx_set_i,
    input  logic            rx_clr_i,
    output logic [NIRQ-1:0] raw_o,
    output logic [NIRQ-1:0] mask_o,
    output logic [NIRQ-1:0] masked_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NIRQ-1:0] raw;
        logic [NIRQ-1:0] mask;
    } irq_t;

    irq_t st_d, st_q;
    logic [NIRQ-1:0] set_v, clr_v;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[TX_BIT] = tx_set_i;
        set_v[RX_BIT] = rx_set_i;
        clr_v[RX_BIT] = rx_clr_i;
        if (clr_we_i) clr_v = clr_v | clr_wdata_i;
        st_d      = st_q;
        st_d.raw  = (st_q.raw & ~clr_v) | set_v;
        if (mask_we_i) st_d.mask = mask_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o    = st_q.raw;
    assign mask_o   = st_q.mask;
    assign masked_o = st_q.raw & st_q.mask;
    assign irq_o    = |masked_o;

    AST_TX_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set_i |=> raw_o[TX_BIT]); // R3
    AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set_i |=> raw_o[RX_BIT]); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !tx_set_i && !rx_set_i) |=> ((raw_o & $past(clr_wdata_i)) == '0)); // R5
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we_i |=> $stable(mask_o)); // R4
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [11:0]       addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              rvalid_o,
    output logic              tx_wr_o,
    output logic [7:0]        tx_byte_o,
    output logic              rx_rd_o,
    input  logic [11:0]       rx_word_i,
    input  logic [8:0]        flags_i,
    input  logic              rx_irq_set_i,
    input  logic              rx_irq_clr_i,
    output logic              irq_o,
    output logic [7:0]        ilpr_o,
    output logic [15:0]       ibrd_o,
    output logic [5:0]        fbrd_o,
    output logic [7:0]        lcr_o,
    output logic [15:0]       cr_o,
    output logic [5:0]        ifls_o,
    output logic [2:0]        dmacr_o
);
    logic [IDX_W-1:0]    idx;
    logic                is_id;
    logic [ID_SEL_W-1:0] id_sel;
    logic [7:0]          id_byte;
    logic                wr, rd;
    logic [NIRQ-1:0]     raw, mask, masked;

    bank_t b_d, b_q;

    uart_regbank_decode u_dec (
        .addr_i   (addr_i),
        .idx_o    (idx),
        .is_id_o  (is_id),
        .id_sel_o (id_sel)
    );

    uart_regbank_idrom u_id (
        .sel_i  (id_sel),
        .byte_o (id_byte)
    );

    assign wr = req_i && we_i;
    assign rd = req_i && !we_i;

    uart_regbank_irq u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mask_we_i    (wr && idx == IX_MASK),
        .mask_wdata_i (wdata_i[NIRQ-1:0]),
        .clr_we_i     (wr && idx == IX_CLR),
        .clr_wdata_i  (wdata_i[NIRQ-1:0]),
        .tx_set_i     (wr && idx == IX_DATA),
        .rx_set_i     (rx_irq_set_i),
        .rx_clr_i     (rx_irq_clr_i),
        .raw_o        (raw),
        .mask_o       (mask),
        .masked_o     (masked),
        .irq_o        (irq_o)
    );

    always_comb begin
        b_d        = b_q;
        b_d.rvalid = rd;
        b_d.rdata  = '0;
        if (wr) begin
            unique case (idx)
                IX_RSR:  b_d.rsr   = '0;
                IX_ILPR: b_d.ilpr  = wdata_i[7:0];
                IX_IBRD: b_d.ibrd  = wdata_i[15:0];
                IX_FBRD: b_d.fbrd  = wdata_i[5:0];
                IX_LCR:  b_d.lcr   = wdata_i[7:0];
                IX_CR:   b_d.cr    = wdata_i[15:0];
                IX_IFLS: b_d.ifls  = wdata_i[5:0];
                IX_DMA:  b_d.dmacr = wdata_i[2:0];
                default: ;
            endcase
        end
        if (rd) begin
            if (is_id) begin
                b_d.rdata = DATA_W'(id_byte);
            end else begin
                unique case (idx)
                    IX_DATA: begin
                        b_d.rdata = DATA_W'(rx_word_i);
                        b_d.rsr   = rx_word_i[11:8];
                    end
                    IX_RSR:  b_d.rdata = DATA_W'(b_q.rsr);
                    IX_FLAG: b_d.rdata = DATA_W'(flags_i);
                    IX_ILPR: b_d.rdata = DATA_W'(b_q.ilpr);
                    IX_IBRD: b_d.rdata = DATA_W'(b_q.ibrd);
                    IX_FBRD: b_d.rdata = DATA_W'(b_q.fbrd);
                    IX_LCR:  b_d.rdata = DATA_W'(b_q.lcr);
                    IX_CR:   b_d.rdata = DATA_W'(b_q.cr);
                    IX_IFLS: b_d.rdata = DATA_W'(b_q.ifls);
                    IX_MASK: b_d.rdata = DATA_W'(mask);
                    IX_RAW:  b_d.rdata = DATA_W'(raw);
                    IX_MIS:  b_d.rdata = DATA_W'(masked);
                    IX_DMA:  b_d.rdata = DATA_W'(b_q.dmacr);
                    default: b_d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q      <= '0;
            b_q.cr   <= CR_RST;
            b_q.ifls <= IFLS_RST;
        end else begin
            b_q <= b_d;
        end
    end

    assign rdata_o   = b_q.rdata;
    assign rvalid_o  = b_q.rvalid;
    assign tx_wr_o   = wr && idx == IX_DATA;
    assign tx_byte_o = wdata_i[7:0];
    assign rx_rd_o   = rd && idx == IX_DATA;
    assign ilpr_o    = b_q.ilpr;
    assign ibrd_o    = b_q.ibrd;
    assign fbrd_o    = b_q.fbrd;
    assign lcr_o     = b_q.lcr;
    assign cr_o      = b_q.cr;
    assign ifls_o    = b_q.ifls;
    assign dmacr_o   = b_q.dmacr;

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid_o); // R11
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid_o); // R11
    AST_RSR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IX_RSR) |=> (b_q.rsr == '0)); // R8
    AST_CR_WRITE_ONLY_BY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && idx == IX_CR) |=> $stable(cr_o)); // R7
endmodule

// File: tb/uart_regbank_tb_top.sv
module uart_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, we_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        rvalid_o, tx_wr_o, rx_rd_o, irq_o;
    logic [7:0]  tx_byte_o, ilpr_o, lcr_o;
    logic [11:0] rx_word_i = '0;
    logic [8:0]  flags_i = 9'h090;
    logic        rx_irq_set_i = 1'b0, rx_irq_clr_i = 1'b0;
    logic [15:0] ibrd_o, cr_o;
    logic [5:0]  fbrd_o, ifls_o;
    logic [2:0]  dmacr_o;

    int checks = 0, failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    uart_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
        .tx_wr_o(tx_wr_o), .tx_byte_o(tx_byte_o), .rx_rd_o(rx_rd_o),
        .rx_word_i(rx_word_i), .flags_i(flags_i), .rx_irq_set_i(rx_irq_set_i),
        .rx_irq_clr_i(rx_irq_clr_i), .irq_o(irq_o), .ilpr_o(ilpr_o),
        .ibrd_o(ibrd_o), .fbrd_o(fbrd_o), .lcr_o(lcr_o), .cr_o(cr_o),
        .ifls_o(ifls_o), .dmacr_o(dmacr_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: R11 read data one cycle after request, nothing otherwise
    always @(negedge clk) begin
        if (rst_n && rvalid_o) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req_i = 1'b1; we_i = 1'b0; addr_i = a;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic rx_event(input logic s, input logic c);
        rx_irq_set_i = s; rx_irq_clr_i = c;
        @(negedge clk);
        rx_irq_set_i = 1'b0; rx_irq_clr_i = 1'b0;
    endtask

    localparam logic [7:0] ID_EXP [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    initial begin : watchdog
        #200000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 irq after reset", 32'(irq_o), 32'd0);
        check("R11 rvalid idle", 32'(rvalid_o), 32'd0);
        bus_read(12'h030, 32'h300, "R1 cr reset");
        bus_read(12'h034, 32'h12, "R1 ifls reset");
        bus_read(12'h038, 32'h0, "R1 mask reset");
        bus_read(12'h03C, 32'h0, "R1 raw reset");
        // R2 config registers truncated to width
        bus_write(12'h024, 32'hFFFF_1234);
        bus_write(12'h028, 32'h0000_00FF);
        bus_write(12'h02C, 32'h0000_0170);
        bus_write(12'h020, 32'h0000_00AB);
        bus_write(12'h048, 32'hFFFF_FFFF);
        bus_write(12'h030, 32'h0001_0301);
        bus_write(12'h034, 32'h0000_00E9);
        bus_read(12'h024, 32'h1234, "R2 ibrd");
        bus_read(12'h028, 32'h3F, "R2 fbrd");
        bus_read(12'h02C, 32'h70, "R2 lcr");
        bus_read(12'h020, 32'hAB, "R2 ilpr");
        bus_read(12'h048, 32'h7, "R2 dmacr");
        bus_read(12'h030, 32'h301, "R2 cr");
        bus_read(12'h034, 32'h29, "R2 ifls");
        check("R2 ibrd_o port", 32'(ibrd_o), 32'h1234);
        // R3 data write
        req_i = 1'b1; we_i = 1'b1; addr_i = 12'h000; wdata_i = 32'h0000_0141;
        #1;
        check("R3 tx_wr_o strobe", 32'(tx_wr_o), 32'd1);
        check("R3 tx_byte_o", 32'(tx_byte_o), 32'h41);
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
        #1;
        check("R3 tx_wr_o drops", 32'(tx_wr_o), 32'd0);
        bus_read(12'h03C, 32'h20, "R3 raw tx bit5");
        check("R4 irq masked off", 32'(irq_o), 32'd0);
        // R4 mask
        bus_write(12'h038, 32'h20);
        check("R4 irq same edge as mask", 32'(irq_o), 32'd1);
        bus_read(12'h040, 32'h20, "R4 masked status");
        // R7 writes to raw, masked, flags, id ignored
        bus_write(12'h03C, 32'h0);
        bus_write(12'h040, 32'h0);
        bus_write(12'h018, 32'hFF);
        bus_write(12'hFE0, 32'hFF);
        bus_read(12'h03C, 32'h20, "R7 raw unchanged by write");
        bus_read(12'h040, 32'h20, "R7 masked unchanged by write");
        bus_read(12'h018, 32'h90, "R7 flags read");
        bus_read(12'hFE0, 32'h11, "R7 id unchanged by write");
        check("R7 cr_o unaffected", 32'(cr_o), 32'h301);
        // R5 write-one-to-clear
        bus_write(12'h044, 32'h10);
        bus_read(12'h03C, 32'h20, "R5 untouched bit stays");
        bus_write(12'h044, 32'h20);
        check("R5 irq after clear", 32'(irq_o), 32'd0);
        bus_read(12'h03C, 32'h0, "R5 raw cleared");
        // R6 receive interrupt events
        rx_event(1'b1, 1'b0);
        bus_read(12'h03C, 32'h10, "R6 rx set");
        bus_write(12'h038, 32'h10);
        check("R4 irq from rx", 32'(irq_o), 32'd1);
        rx_event(1'b1, 1'b1);
        bus_read(12'h03C, 32'h10, "R6 set wins over clear");
        rx_event(1'b0, 1'b1);
        check("R6 irq after rx clear", 32'(irq_o), 32'd0);
        bus_read(12'h03C, 32'h0, "R6 rx cleared");
        // R3/R8 data read and receive status
        rx_word_i = 12'h5A3;
        req_i = 1'b1; we_i = 1'b0; addr_i = 12'h000;
        exp_q.push_back(32'h5A3); tag_q.push_back("R3 data read word");
        #1;
        check("R3 rx_rd_o strobe", 32'(rx_rd_o), 32'd1);
        @(negedge clk);
        req_i = 1'b0;
        bus_read(12'h004, 32'h5, "R8 rsr captured");
        bus_write(12'h004, 32'h0);
        bus_read(12'h004, 32'h0, "R8 rsr cleared");
        // R9 identification
        for (int i = 0; i < 8; i++) begin
            bus_read(12'hFE0 + 12'(i * 4), 32'(ID_EXP[i]), "R9 id byte");
        end
        // R10 unmapped
        bus_read(12'h008, 32'h0, "R10 index 2");
        bus_read(12'h01C, 32'h0, "R10 index 7");
        bus_read(12'h044, 32'h0, "R10 clear reg read");
        bus_read(12'h800, 32'h0, "R10 mid window");
        bus_read(12'hFDC, 32'h0, "R10 below id");
        repeat (3) @(negedge clk);
        check("R11 all reads answered", 32'(exp_q.size()), 32'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule